// File: doc/BRIEF.md
# Paged EEPROM Write Controller with Completion Polling

This block is the host side of a byte-wide, page-programmed nonvolatile memory. A request names a page, a starting byte offset inside that page and a byte count of 1 to 64. The controller then draws bytes one at a time from a first-word-fall-through FIFO and loads each one into the memory with its own write-enable pulse. Chip select stays low for the whole operation. The loads follow one another closely, so that the memory's load window never runs out between two bytes.

Once the last byte is loaded, the memory programs the page internally. The controller finds the end of programming by reading the memory back at the address of the last byte it loaded. A mode bit chosen per request sets how each read is judged. In the default mode, the write is complete when data bit 7 matches bit 7 of the last byte written. In toggle mode, it is complete when two reads in a row return the same bit 6. After a recovery delay, the controller emits one done pulse with a status code. The status reports a clean finish, a polling timeout, or an early stop because the FIFO ran dry in the middle of a page.

Top module: `pgwr_host`

## Requirements
- R1: `req_ready` is high while idle. It drops in the cycle after a request is accepted and returns high in the same cycle as the single one-cycle `done` pulse for that request.
- R2: Byte k of a request (k counting from 0) is written at address bits [14:6] equal to `req_page` and bits [5:0] equal to (`req_ofs` + k) mod 64. Its data is the k-th FIFO word. `req_len_m1` + 1 bytes are written when the FIFO keeps up.
- R3: Each write-enable low pulse lasts exactly `WL_CYC` cycles. During the pulse chip select is low, output enable is high, and address and data are stable.
- R4: Within one request, consecutive write-enable falling edges are at most `SU_CYC+WL_CYC+WH_CYC+GAP_CYC+2` cycles apart.
- R5: With `req_toggle`=0, a read counts as complete when `mem_stat[1]` (data bit 7) equals bit 7 of the last byte written.
- R6: With `req_toggle`=1, a read counts as complete when `mem_stat[0]` (data bit 6) equals the value from the previous read of the same poll. The first read never completes. Every poll read uses the address of the last byte written.
- R7: Each read holds output enable low for exactly `ACC_CYC` cycles, unless a timeout cuts it short. Between reads, output enable stays high for at least `OEH_CYC` cycles. The data bus is never driven while output enable is low.
- R8: On a completed poll, `done` rises exactly `REC_CYC` cycles after output enable returns high from the completing read.
- R9: If polling has not completed within `TIMEOUT_CYC` cycles of its start, it stops. `done` then follows after `REC_CYC` cycles with status 1.
- R10: After at least one byte has been loaded, if the FIFO stays empty for `GAP_CYC` cycles, loading stops. The last loaded byte is polled and status 2 is reported.
- R11: `status` is valid while `done` is high: 0 means success, 1 means timeout, 2 means FIFO underrun, and 3 never occurs.
- R12: In idle and after reset, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are high and `mem_dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request taken this cycle when valid |
| req_page | input | PG_W | Page number, placed on the upper address bits |
| req_ofs | input | OFS_W | Offset of the first byte inside the page |
| req_len_m1 | input | OFS_W | Byte count minus one |
| req_toggle | input | 1 | 0: bit-7 compare polling, 1: bit-6 toggle polling |
| fifo_empty | input | 1 | Source FIFO has no word |
| fifo_data | input | DATA_W | Head word of the FIFO |
| fifo_pop | output | 1 | Removes the head word |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | PG_W+OFS_W | Memory address |
| mem_dout | output | DATA_W | Data driven toward the memory |
| mem_dout_en | output | 1 | Enables the data-bus driver |
| mem_stat | input | 2 | Memory data bits 7 (bit 1) and 6 (bit 0) during reads |
| done | output | 1 | One-cycle end-of-request pulse |
| status | output | 2 | Completion code, valid with done |

## Verification
A wrong phase counter or state shows at the strobe pins in the same operation. A write-enable width or a read-access width that differs from the parameter can be seen at the first pulse. An offset counter that is off by one shows up at the very first write, or after the wrap in a page that straddles offset 63. A fault in the polling judge shows in one of two ways. The done pulse can come before the modelled memory has finished programming, which the bench measures against the model's busy window. Or it can never come, and the request ends with status 1 instead of 0 about `TIMEOUT_CYC` cycles later. Underrun and timeout paths are forced on purpose, so a missing status code shows at that request's done pulse.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_SETUP, S_WLOW, S_WHIGH, S_OEHI, S_OELO, S_RECOV
  } pgwr_state_e;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_TIMEOUT  = 2'd1,
    ST_UNDERRUN = 2'd2
  } pgwr_status_e;

  function automatic int pgwr_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pgwr_phase_timer.sv
// Loaded with N-1 on entry to a phase, so the phase lasts exactly N cycles.
module pgwr_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/pgwr_limit_cnt.sv
// Counts enabled cycles since the last clear; hit once LIMIT are seen.
module pgwr_limit_cnt #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)      cnt <= '0;
    else if (en && !hit) cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == CW'(LIMIT));
endmodule

// File: rtl/pgwr_poll_judge.sv
// Decides whether one read-back sample ends the programming wait.
module pgwr_poll_judge (
  input  logic       toggle_mode,
  input  logic [1:0] stat,       // [1] = data bit 7, [0] = data bit 6
  input  logic       want_d7,
  input  logic       prev6,
  input  logic       have_prev,
  output logic       complete
);
  always_comb begin
    if (toggle_mode) complete = have_prev && (stat[0] == prev6);
    else             complete = (stat[1] == want_d7);
  end
endmodule

// File: rtl/pgwr_host.sv
module pgwr_host
  import pgwr_pkg::*;
#(
  parameter int PG_W        = 9,
  parameter int OFS_W       = 6,
  parameter int DATA_W      = 8,
  parameter int SU_CYC      = 2,       // address/data setup before WE falls
  parameter int WL_CYC      = 10,      // WE low width
  parameter int WH_CYC      = 10,      // WE high after each load
  parameter int OEH_CYC     = 16,      // OE high between reads
  parameter int ACC_CYC     = 11,      // OE low before sampling
  parameter int REC_CYC     = 1000,    // wait after completion
  parameter int GAP_CYC     = 2000,    // max FIFO stall inside a page
  parameter int TIMEOUT_CYC = 2000000  // polling limit
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [PG_W-1:0]          req_page,
  input  logic [OFS_W-1:0]         req_ofs,
  input  logic [OFS_W-1:0]         req_len_m1,
  input  logic                     req_toggle,
  input  logic                     fifo_empty,
  input  logic [DATA_W-1:0]        fifo_data,
  output logic                     fifo_pop,
  output logic                     mem_ce_n,
  output logic                     mem_we_n,
  output logic                     mem_oe_n,
  output logic [PG_W+OFS_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]        mem_dout,
  output logic                     mem_dout_en,
  input  logic [1:0]               mem_stat,
  output logic                     done,
  output logic [1:0]               status
);
  localparam int TMAX = pgwr_max(pgwr_max(pgwr_max(SU_CYC, WL_CYC), pgwr_max(WH_CYC, OEH_CYC)),
                                 pgwr_max(ACC_CYC, REC_CYC));
  localparam int TW   = $clog2(TMAX + 1);

  pgwr_state_e     state, nxt;
  pgwr_status_e    st_q;
  logic [OFS_W-1:0] left_q;
  logic            toggle_q, last_d7, prev6, have_prev, loaded_any;
  logic            t_load, t_exp, gap_hit, to_hit, complete, accept, poll_ph;
  logic [TW-1:0]   t_val;

  assign accept  = req_valid && req_ready;
  assign poll_ph = (state == S_OEHI) || (state == S_OELO);

  pgwr_phase_timer #(.W(TW)) u_phase (
    .clk(clk), .rst(rst), .load(t_load), .val(t_val), .expired(t_exp)
  );

  pgwr_limit_cnt #(.LIMIT(GAP_CYC)) u_gap (
    .clk(clk), .rst(rst), .clr(state != S_FETCH),
    .en(fifo_empty && loaded_any), .hit(gap_hit)
  );

  pgwr_limit_cnt #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk(clk), .rst(rst), .clr(!poll_ph), .en(1'b1), .hit(to_hit)
  );

  pgwr_poll_judge u_judge (
    .toggle_mode(toggle_q), .stat(mem_stat), .want_d7(last_d7),
    .prev6(prev6), .have_prev(have_prev), .complete(complete)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:  if (accept) nxt = S_FETCH;
      S_FETCH: if (!fifo_empty) nxt = S_SETUP;
               else if (gap_hit) nxt = S_OEHI;
      S_SETUP: if (t_exp) nxt = S_WLOW;
      S_WLOW:  if (t_exp) nxt = S_WHIGH;
      S_WHIGH: if (t_exp) nxt = (left_q == '0) ? S_OEHI : S_FETCH;
      S_OEHI:  if (to_hit) nxt = S_RECOV;
               else if (t_exp) nxt = S_OELO;
      S_OELO:  if (t_exp && complete) nxt = S_RECOV;
               else if (to_hit) nxt = S_RECOV;
               else if (t_exp) nxt = S_OEHI;
      S_RECOV: if (t_exp) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign t_load = (nxt != state);

  always_comb begin
    unique case (nxt)
      S_SETUP: t_val = TW'(SU_CYC - 1);
      S_WLOW:  t_val = TW'(WL_CYC - 1);
      S_WHIGH: t_val = TW'(WH_CYC - 1);
      S_OEHI:  t_val = TW'(OEH_CYC - 1);
      S_OELO:  t_val = TW'(ACC_CYC - 1);
      S_RECOV: t_val = TW'(REC_CYC - 1);
      default: t_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      st_q        <= ST_OK;
      req_ready   <= 1'b1;
      fifo_pop    <= 1'b0;
      mem_ce_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      mem_addr    <= '0;
      mem_dout    <= '0;
      mem_dout_en <= 1'b0;
      done        <= 1'b0;
      status      <= ST_OK;
      left_q      <= '0;
      toggle_q    <= 1'b0;
      last_d7     <= 1'b0;
      prev6       <= 1'b0;
      have_prev   <= 1'b0;
      loaded_any  <= 1'b0;
    end else begin
      state    <= nxt;
      done     <= 1'b0;
      fifo_pop <= 1'b0;
      unique case (state)
        S_IDLE: if (accept) begin
          req_ready  <= 1'b0;
          mem_ce_n   <= 1'b0;
          mem_addr   <= {req_page, req_ofs};
          left_q     <= req_len_m1;
          toggle_q   <= req_toggle;
          loaded_any <= 1'b0;
          have_prev  <= 1'b0;
          st_q       <= ST_OK;
        end
        S_FETCH: if (!fifo_empty) begin
          fifo_pop    <= 1'b1;
          mem_dout    <= fifo_data;
          mem_dout_en <= 1'b1;
          last_d7     <= fifo_data[DATA_W-1];
          loaded_any  <= 1'b1;
          // offset advances only between bytes, so the poll address stays on the last one
          if (loaded_any) mem_addr[OFS_W-1:0] <= mem_addr[OFS_W-1:0] + 1'b1;
        end else if (gap_hit) begin
          st_q        <= ST_UNDERRUN;
          mem_dout_en <= 1'b0;
          have_prev   <= 1'b0;
        end
        S_SETUP: if (t_exp) mem_we_n <= 1'b0;
        S_WLOW:  if (t_exp) mem_we_n <= 1'b1;
        S_WHIGH: if (t_exp) begin
          if (left_q == '0) begin
            mem_dout_en <= 1'b0;
            have_prev   <= 1'b0;
          end else begin
            left_q <= left_q - 1'b1;
          end
        end
        S_OEHI: begin
          if (to_hit) st_q <= ST_TIMEOUT;
          else if (t_exp) mem_oe_n <= 1'b0;
        end
        S_OELO: begin
          if (t_exp || to_hit) mem_oe_n <= 1'b1;
          if (t_exp) begin
            prev6     <= mem_stat[0];
            have_prev <= 1'b1;
          end
          if (!(t_exp && complete) && to_hit) st_q <= ST_TIMEOUT;
        end
        S_RECOV: if (t_exp) begin
          done      <= 1'b1;
          status    <= st_q;
          req_ready <= 1'b1;
          mem_ce_n  <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pgwr_host_chk.sv
module pgwr_host_chk #(
  parameter int PG_W   = 9,
  parameter int OFS_W  = 6,
  parameter int DATA_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  mem_ce_n,
  input logic                  mem_we_n,
  input logic                  mem_oe_n,
  input logic [PG_W+OFS_W-1:0] mem_addr,
  input logic [DATA_W-1:0]     mem_dout,
  input logic                  mem_dout_en,
  input logic                  done,
  input logic [1:0]            status
);
  // R3
  we_strobe_ctx_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dout_en));
  // R3
  we_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dout)));
  // R7
  rd_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dout_en);
  // R6
  poll_addr_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));
  // R1
  accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R1
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R1
  done_ready_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);
  // R11
  status_code_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (status != 2'd3));
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (req_ready && !done) |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dout_en));
endmodule

bind pgwr_host pgwr_host_chk #(.PG_W(PG_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
  .done(done), .status(status)
);

// File: tb/pgwr_host_tb.sv
module pgwr_host_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SU = 2, WL = 3, WH = 2, OEH = 3, ACC = 2, REC = 20, GAP = 30, TMO = 400;
  localparam int BND = SU + WL + WH + GAP + 2;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_toggle = 1'b0;
  logic [8:0] req_page = '0;
  logic [5:0] req_ofs = '0, req_len_m1 = '0;
  logic fifo_empty, fifo_pop, req_ready;
  logic [7:0] fifo_data, mem_dout;
  logic mem_ce_n, mem_we_n, mem_oe_n, mem_dout_en, done;
  logic [14:0] mem_addr;
  logic [1:0] mem_stat, status;

  pgwr_host #(.SU_CYC(SU), .WL_CYC(WL), .WH_CYC(WH), .OEH_CYC(OEH), .ACC_CYC(ACC),
              .REC_CYC(REC), .GAP_CYC(GAP), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_page(req_page), .req_ofs(req_ofs), .req_len_m1(req_len_m1), .req_toggle(req_toggle),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_stat(mem_stat),
    .done(done), .status(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // request context, written only by the stimulus tasks
  logic [7:0] arr [64];
  int base = 0, wb = 0, avail = 0, busy_len = 10, req_no = 0;
  logic [8:0] exp_page = '0;
  logic [5:0] exp_ofs = '0;
  logic stuck = 1'b0;

  // memory and FIFO model, written only by the monitor
  logic [7:0] page_buf [64];
  int busy = 0, busy_end = 0, rd_ptr = 0, wcount = 0, seen_req = 0;
  int last_fall = 0, oe_fall = 0, oe_rise = 0, last_rise = 0, done_cnt = 0, done_cyc = 0;
  int wl_err = 0, spc_err = 0, oe_err = 0, pa_err = 0, addr_err = 0, dw_err = 0;
  bit have_fall = 0, have_rise = 0;
  logic tog = 1'b0, last7 = 1'b0, prev_we = 1'b1, prev_oe = 1'b1, prev_done = 1'b0;
  logic [14:0] last_waddr = '0;

  assign fifo_empty = (rd_ptr - base) >= avail;
  assign fifo_data  = arr[6'(rd_ptr - base)];
  assign mem_stat   = (stuck || busy > 0) ? {~last7, tog} : page_buf[mem_addr[5:0]][7:6];

  always @(negedge clk) begin
    int idx, w;
    if (req_no != seen_req) begin
      have_fall = 0; have_rise = 0; seen_req = req_no;
    end
    if (busy > 0) begin
      busy = busy - 1;
      if (busy == 0) busy_end = cyc;
    end
    if (prev_we && !mem_we_n) begin
      if (have_fall && (cyc - last_fall) > BND) spc_err++;   // R4
      have_fall = 1; last_fall = cyc;
    end
    if (!prev_we && mem_we_n) begin
      if (cyc - last_fall != WL) wl_err++;                    // R3
      idx = wcount - wb;
      if (mem_addr[14:6] != exp_page || mem_addr[5:0] != 6'(exp_ofs + 6'(idx)) ||
          mem_dout != arr[6'(idx)]) addr_err++;               // R2
      page_buf[mem_addr[5:0]] = mem_dout;
      last7 = mem_dout[7]; last_waddr = mem_addr; busy = busy_len;
      last_rise = cyc; wcount++;
    end
    if (prev_oe && !mem_oe_n) begin
      tog = ~tog;
      if (have_rise && (cyc - oe_rise) < OEH) oe_err++;       // R7
      if (mem_addr != last_waddr || mem_dout_en) pa_err++;    // R6
      oe_fall = cyc;
    end
    if (!prev_oe && mem_oe_n) begin
      w = cyc - oe_fall;
      if (w > ACC || (w < ACC && !stuck)) oe_err++;           // R7
      have_rise = 1; oe_rise = cyc;
    end
    if (done) begin
      if (prev_done) dw_err++;                                // R1
      done_cnt++; done_cyc = cyc;
    end
    if (fifo_pop) rd_ptr++;
    prev_we = mem_we_n; prev_oe = mem_oe_n; prev_done = done;
  end

  task automatic run_req(input logic [8:0] pg, input logic [5:0] of, input logic [5:0] lm1,
                         input logic tg, input int navail, input bit stk, input int blen,
                         input logic [1:0] exp_st, input string tag);
    int a0, d0, g, nexp, d, tgt;
    for (int i = 0; i < 64; i++) arr[i] = 8'($urandom);
    base = rd_ptr; wb = wcount; avail = navail; exp_page = pg; exp_ofs = of;
    stuck = stk; busy_len = blen; req_no++;
    a0 = addr_err; d0 = done_cnt;
    @(negedge clk);
    req_page = pg; req_ofs = of; req_len_m1 = lm1; req_toggle = tg; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R1 ready low after accept", int'(req_ready), 0);
    g = 0;
    while (done_cnt == d0 && g < 50000) begin @(negedge clk); g++; end
    chk(done_cnt > d0, {tag, " done reached"}, done_cnt - d0, 1);
    chk(status == exp_st, {"R11 status for ", tag}, int'(status), int'(exp_st));
    chk(req_ready, "R1 ready back with done", int'(req_ready), 1);
    nexp = (int'(lm1) + 1 < navail) ? int'(lm1) + 1 : navail;
    chk(wcount - wb == nexp, {"R2 byte count ", tag}, wcount - wb, nexp);
    chk(addr_err == a0, "R2 address/data of loads", addr_err - a0, 0);
    if (exp_st == 2'd0) begin
      chk(done_cyc - oe_rise == REC, "R8 recovery delay", done_cyc - oe_rise, REC);
      d = done_cyc - busy_end;
      chk(d >= REC && d <= REC + 2*(OEH + ACC) + 6, {tag, " completion vs busy end"}, d, REC);
    end
    if (exp_st == 2'd1) begin
      tgt = last_rise + WH + TMO + 1 + REC;
      chk(done_cyc >= tgt - 2 && done_cyc <= tgt + 2, "R9 timeout instant", done_cyc, tgt);
    end
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 + 1 && !done, "R1 single done pulse", done_cnt - d0, 1);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dout_en, "R12 idle strobes",
        int'({mem_ce_n, mem_we_n, mem_oe_n, mem_dout_en}), 14);
    stuck = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R1 watchdog expired", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !done, "R1 ready after reset", int'(req_ready), 1);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dout_en, "R12 strobes after reset",
        int'({mem_ce_n, mem_we_n, mem_oe_n, mem_dout_en}), 14);
    // directed corners
    run_req(9'h1FF, 6'd0,  6'd0,  1'b0, 1,  0, 40,  2'd0, "R5");
    run_req(9'h0A5, 6'd60, 6'd63, 1'b1, 64, 0, 100, 2'd0, "R6");
    run_req(9'h033, 6'd60, 6'd7,  1'b0, 8,  0, 1,   2'd0, "R5");
    run_req(9'h100, 6'd5,  6'd2,  1'b1, 3,  0, 1,   2'd0, "R6");
    run_req(9'h055, 6'd10, 6'd9,  1'b0, 4,  0, 30,  2'd2, "R10");
    run_req(9'h07E, 6'd20, 6'd3,  1'b0, 4,  1, 30,  2'd1, "R9");
    run_req(9'h0E1, 6'd63, 6'd1,  1'b1, 2,  1, 30,  2'd1, "R9");
    // random mix
    for (int k = 0; k < 14; k++) begin
      logic tg;
      logic [5:0] lm;
      tg = 1'($urandom);
      lm = 6'($urandom % 20);
      run_req(9'($urandom), 6'($urandom), lm, tg, int'(lm) + 1, 0,
              10 + int'($urandom % 140), 2'd0, tg ? "R6" : "R5");
    end
    chk(wl_err == 0, "R3 write pulse width", wl_err, 0);
    chk(spc_err == 0, "R4 write spacing", spc_err, 0);
    chk(oe_err == 0, "R7 read strobe timing", oe_err, 0);
    chk(pa_err == 0, "R6 poll address and bus release", pa_err, 0);
    chk(dw_err == 0, "R1 done width", dw_err, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule